// File: doc/BRIEF.md
# Idle-State Auto-Demotion Predictor

This block sits in each core between the resolved idle-state request and the sequencer that carries out the entry. It can replace a deep idle request with a shallower one when recent behaviour suggests that the deep state would not pay off. Two measurements drive that choice.

The first measurement is the interrupt rate, which is the number of interrupt cycles counted in a programmable window of clock cycles. The second is the recent deep-state residency, which is the mean of the last four measured stays in a deep state. When interrupts are frequent and stays are short, a C6 or C7 request may be granted as C3. A C3, C6 or C7 request may be granted as C1. The demotion to C1 uses its own, higher interrupt-rate threshold.

Each of the two demotion options has its own enable. All other requests are forwarded unchanged, one cycle later, on the grant output.

Top module: `idle_demote_predictor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `grant_valid_o` is 0 and `grant_state_o` is 0 (C0). The interrupt rate and all four residency samples start at zero.
- R2: State codes are C0=0, C1=1, C3=3, C6=6 and C7=7, and only these codes are requested. `grant_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. In that cycle, `grant_state_o` carries the decision for that request.
- R3: A C0 or C1 request is granted unchanged.
- R4: The window restarts every `win_len_i` cycles (`win_len_i` >= 1). The interrupt rate is the number of cycles with `irq_i` high in the last completed window. Decisions use that value until the next window completes.
- R5: The residency history is floor((s0+s1+s2+s3)/4) over the four newest samples. A sample is the number of cycles counted from the cycle after deep-state entry up to the wake.
- R6: A C6 or C7 request is granted as C3 when all of these hold: `en_c3_i` is high, rate >= `rate_thr_c3_i`, history < `res_thr_i`, and the C1 option does not qualify.
- R7: A C3, C6 or C7 request is granted as C1 when all of these hold: `en_c1_i` is high, rate >= `rate_thr_c1_i`, and history < `res_thr_i`.
- R8: When both options qualify for a C6 or C7 request, C1 is granted.
- R9: A deep request for which no option qualifies is granted unchanged. A C3 request is never granted as C3 through the C3 option. A grant is never deeper than its request.
- R10: A disabled option is never applied, whatever the rate and history.
- R11: A wake pulse while not in a deep state adds no sample. A deep-entry pulse in the same cycle as a wake restarts the stay.
- R12: The interrupt count saturates at 2^CNT_W-1 instead of wrapping. The residency counter saturates at 2^RES_W-1.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt seen this cycle |
| deep_enter_i | input | 1 | Core has entered a deep state (pulse) |
| wake_i | input | 1 | Core has woken (pulse) |
| req_valid_i | input | 1 | Idle request present |
| req_state_i | input | 3 | Requested state code |
| en_c3_i | input | 1 | Enable for demotion to C3 |
| en_c1_i | input | 1 | Enable for demotion to C1 |
| win_len_i | input | 16 | Sampling window length in cycles |
| rate_thr_c3_i | input | 8 | Interrupt-rate threshold for demotion to C3 |
| rate_thr_c1_i | input | 8 | Interrupt-rate threshold for demotion to C1 |
| res_thr_i | input | 16 | Residency history below which demotion is allowed |
| grant_valid_o | output | 1 | Granted state present |
| grant_state_o | output | 3 | Granted state code |

## Verification
The assertions take three things about the inputs for granted: a request carries only one of the five legal codes, `req_valid_i` stays low during reset, and the enables are stable for the cycle in which a request is sampled. The stimulus drives only legal codes, holds requests off until reset is released, and changes the configuration only between requests. The C1 threshold is kept at or above the C3 threshold so that the rate ordering between the two options holds.

// File: rtl/idp_pkg.sv
package idp_pkg;

    typedef enum logic [2:0] {
        ST_C0 = 3'd0,
        ST_C1 = 3'd1,
        ST_C3 = 3'd3,
        ST_C6 = 3'd6,
        ST_C7 = 3'd7
    } cstate_e;

    localparam int HIST_SHIFT = 2;
    localparam int HIST_DEPTH = 1 << HIST_SHIFT;

    typedef struct packed {
        logic to_c1;
        logic to_c3;
    } qual_t;

    function automatic logic is_legal(logic [2:0] code);
        return (code == ST_C0) || (code == ST_C1) || (code == ST_C3) ||
               (code == ST_C6) || (code == ST_C7);
    endfunction

    // Apply the qualified options to a request; C1 outranks C3.
    function automatic cstate_e pick_state(cstate_e req, qual_t q);
        cstate_e res;
        res = req;
        unique case (req)
            ST_C3:        if (q.to_c1) res = ST_C1;
            ST_C6, ST_C7: begin
                if (q.to_c1)      res = ST_C1;
                else if (q.to_c3) res = ST_C3;
            end
            default:      res = req;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/idp_rate_meter.sv
module idp_rate_meter #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic [CNT_W-1:0] rate_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [WIN_W-1:0] pos_q;
    logic             win_last;

    assign cnt_next = (irq_i && (cnt_q != CNT_MAX)) ? cnt_q + CNT_W'(1) : cnt_q;
    assign win_last = (pos_q >= (win_len_i - WIN_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pos_q  <= '0;
            rate_o <= '0;
        end else if (win_last) begin
            rate_o <= cnt_next;
            cnt_q  <= '0;
            pos_q  <= '0;
        end else begin
            cnt_q  <= cnt_next;
            pos_q  <= pos_q + WIN_W'(1);
        end
    end
endmodule

// File: rtl/idp_residency_hist.sv
module idp_residency_hist
    import idp_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deep_enter_i,
    input  logic             wake_i,
    output logic [RES_W-1:0] avg_o
);
    localparam int                SUM_W   = RES_W + HIST_SHIFT;
    localparam logic [RES_W-1:0]  RUN_MAX = {RES_W{1'b1}};

    logic [RES_W-1:0] run_q;
    logic             in_deep_q;
    logic [RES_W-1:0] smp_q [HIST_DEPTH];
    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            in_deep_q <= 1'b0;
            for (int i = 0; i < HIST_DEPTH; i++) smp_q[i] <= '0;
        end else if (deep_enter_i) begin
            run_q     <= '0;
            in_deep_q <= 1'b1;
        end else if (in_deep_q) begin
            if (wake_i) begin
                in_deep_q <= 1'b0;
                smp_q[0]  <= run_q;
                for (int i = 1; i < HIST_DEPTH; i++) smp_q[i] <= smp_q[i-1];
            end else if (run_q != RUN_MAX) begin
                run_q <= run_q + RES_W'(1);
            end
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < HIST_DEPTH; i++) sum = sum + SUM_W'(smp_q[i]);
    end

    assign avg_o = sum[SUM_W-1:HIST_SHIFT];
endmodule

// File: rtl/idp_decider.sv
module idp_decider
    import idp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int RES_W = 16
) (
    input  cstate_e          req_i,
    input  logic [CNT_W-1:0] rate_i,
    input  logic [RES_W-1:0] avg_i,
    input  logic [CNT_W-1:0] thr_c3_i,
    input  logic [CNT_W-1:0] thr_c1_i,
    input  logic [RES_W-1:0] res_thr_i,
    input  logic             en_c3_i,
    input  logic             en_c1_i,
    output cstate_e          grant_o
);
    qual_t q;
    logic  short_stay;

    assign short_stay = (avg_i < res_thr_i);
    assign q.to_c1    = en_c1_i && short_stay && (rate_i >= thr_c1_i);
    assign q.to_c3    = en_c3_i && short_stay && (rate_i >= thr_c3_i);
    assign grant_o    = pick_state(req_i, q);
endmodule

// File: rtl/idle_demote_predictor.sv
module idle_demote_predictor
    import idp_pkg::*;
#(
    parameter int WIN_W = 16,
    parameter int CNT_W = 8,
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_i,
    input  logic             deep_enter_i,
    input  logic             wake_i,
    input  logic             req_valid_i,
    input  logic [2:0]       req_state_i,
    input  logic             en_c3_i,
    input  logic             en_c1_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic [CNT_W-1:0] rate_thr_c3_i,
    input  logic [CNT_W-1:0] rate_thr_c1_i,
    input  logic [RES_W-1:0] res_thr_i,
    output logic             grant_valid_o,
    output logic [2:0]       grant_state_o
);
    logic [CNT_W-1:0] rate;
    logic [RES_W-1:0] avg;
    cstate_e          decided;

    idp_rate_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst(rst), .irq_i(irq_i),
        .win_len_i(win_len_i), .rate_o(rate)
    );

    idp_residency_hist #(.RES_W(RES_W)) u_hist (
        .clk(clk), .rst(rst), .deep_enter_i(deep_enter_i),
        .wake_i(wake_i), .avg_o(avg)
    );

    idp_decider #(.CNT_W(CNT_W), .RES_W(RES_W)) u_dec (
        .req_i(cstate_e'(req_state_i)), .rate_i(rate), .avg_i(avg),
        .thr_c3_i(rate_thr_c3_i), .thr_c1_i(rate_thr_c1_i),
        .res_thr_i(res_thr_i), .en_c3_i(en_c3_i), .en_c1_i(en_c1_i),
        .grant_o(decided)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid_o <= 1'b0;
            grant_state_o <= ST_C0;
        end else begin
            grant_valid_o <= req_valid_i;
            if (req_valid_i) grant_state_o <= decided;
        end
    end
endmodule

// File: rtl/idp_checker.sv
module idp_checker
    import idp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid_i,
    input logic [2:0] req_state_i,
    input logic       en_c3_i,
    input logic       en_c1_i,
    input logic       grant_valid_o,
    input logic [2:0] grant_state_o
);
    logic seen  = 1'b0;
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        armed <= !rst;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!seen)
        $past(rst) |-> (!grant_valid_o && grant_state_o == ST_C0));

    assert_legal_request_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |-> is_legal(req_state_i));

    assert_grant_follows_req_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        grant_valid_o == $past(req_valid_i));

    assert_shallow_passes_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(req_valid_i) && $past(req_state_i) <= 3'd1) |-> grant_state_o == $past(req_state_i));

    assert_never_deeper_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        grant_valid_o |-> grant_state_o <= $past(req_state_i));

    assert_c3_not_self_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(req_valid_i) && $past(req_state_i) == ST_C3) |->
        (grant_state_o == ST_C3 || grant_state_o == ST_C1));

    assert_c1_needs_enable_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        (grant_valid_o && !$past(en_c1_i) && $past(req_state_i) != ST_C1) |-> grant_state_o != ST_C1);

    assert_c3_needs_enable_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        (grant_valid_o && !$past(en_c3_i) && $past(req_state_i) != ST_C3) |-> grant_state_o != ST_C3);
endmodule

bind idle_demote_predictor idp_checker u_chk (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_state_i(req_state_i),
    .en_c3_i(en_c3_i), .en_c1_i(en_c1_i),
    .grant_valid_o(grant_valid_o), .grant_state_o(grant_state_o)
);

// File: tb/tb_idle_demote_predictor.sv
module tb_idle_demote_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_W = 16;
    localparam int CNT_W = 8;
    localparam int RES_W = 16;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam int RMAX  = (1 << RES_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_i = 1'b0, deep_enter_i = 1'b0, wake_i = 1'b0;
    logic req_valid_i = 1'b0;
    logic [2:0] req_state_i = 3'd0;
    logic en_c3_i = 1'b1, en_c1_i = 1'b1;
    logic [WIN_W-1:0] win_len_i = 16'd20;
    logic [CNT_W-1:0] rate_thr_c3_i = 8'd4, rate_thr_c1_i = 8'd8;
    logic [RES_W-1:0] res_thr_i = 16'd50;
    logic grant_valid_o;
    logic [2:0] grant_state_o;

    int checks = 0, fails = 0;
    int irq_period = 0;
    bit done = 0;

    idle_demote_predictor #(.WIN_W(WIN_W), .CNT_W(CNT_W), .RES_W(RES_W)) dut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .deep_enter_i(deep_enter_i),
        .wake_i(wake_i), .req_valid_i(req_valid_i), .req_state_i(req_state_i),
        .en_c3_i(en_c3_i), .en_c1_i(en_c1_i), .win_len_i(win_len_i),
        .rate_thr_c3_i(rate_thr_c3_i), .rate_thr_c1_i(rate_thr_c1_i),
        .res_thr_i(res_thr_i), .grant_valid_o(grant_valid_o), .grant_state_o(grant_state_o)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_rate, m_icnt, m_wcnt, m_rcnt;
    bit m_in_deep, m_exp_valid;
    int m_exp_state;
    string m_tag = "R2";
    int m_hist[$];

    function automatic int model_pick(int req, int avg);
        bit q1, q3;
        q1 = en_c1_i && (m_rate >= int'(rate_thr_c1_i)) && (avg < int'(res_thr_i));
        q3 = en_c3_i && (m_rate >= int'(rate_thr_c3_i)) && (avg < int'(res_thr_i));
        if (req <= 1) return req;
        if (q1) return 1;
        if (req != 3 && q3) return 3;
        return req;
    endfunction

    always @(posedge clk) begin
        int avg;
        if (rst) begin
            m_rate = 0; m_icnt = 0; m_wcnt = 0; m_rcnt = 0;
            m_in_deep = 0; m_exp_valid = 0; m_exp_state = 0;
            m_hist = '{0, 0, 0, 0};
        end else begin
            avg = (m_hist[0] + m_hist[1] + m_hist[2] + m_hist[3]) / 4;
            m_exp_valid = req_valid_i;
            if (req_valid_i) begin
                m_exp_state = model_pick(int'(req_state_i), avg);
                if (req_state_i <= 3'd1)                    m_tag = "R3";
                else if (m_exp_state == 1)                  m_tag = "R7";
                else if (m_exp_state == 3 && req_state_i != 3'd3) m_tag = "R6";
                else                                        m_tag = "R9";
            end else m_tag = "R2";
            if (m_wcnt + 1 >= int'(win_len_i)) begin
                m_rate = (m_icnt + irq_i > CMAX) ? CMAX : m_icnt + irq_i;
                m_icnt = 0; m_wcnt = 0;
            end else begin
                m_icnt = (m_icnt + irq_i > CMAX) ? CMAX : m_icnt + irq_i;
                m_wcnt++;
            end
            if (deep_enter_i) begin
                m_in_deep = 1; m_rcnt = 0;
            end else if (m_in_deep) begin
                if (wake_i) begin
                    m_hist.push_front(m_rcnt);
                    void'(m_hist.pop_back());
                    m_in_deep = 0;
                end else if (m_rcnt < RMAX) m_rcnt++;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (grant_valid_o !== m_exp_valid ||
                (m_exp_valid && int'(grant_state_o) != m_exp_state)) begin
                fails++;
                $display("FAIL %s model: valid=%0b state=%0d expected valid=%0b state=%0d",
                         m_tag, grant_valid_o, grant_state_o, m_exp_valid, m_exp_state);
            end
        end
    end

    // Periodic interrupt source
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            irq_i = (irq_period > 0) && (k % irq_period == 0);
        end
    end

    task automatic request(input logic [2:0] st, input logic [2:0] exp, input string tag);
        @(negedge clk);
        req_valid_i = 1'b1; req_state_i = st;
        @(negedge clk);
        req_valid_i = 1'b0;
        checks++;
        if (grant_valid_o !== 1'b1 || grant_state_o !== exp) begin
            fails++;
            $display("FAIL %s req=%0d: got valid=%0b state=%0d expected valid=1 state=%0d",
                     tag, st, grant_valid_o, grant_state_o, exp);
        end
    endtask

    task automatic deep_stay(input int n);
        @(negedge clk); deep_enter_i = 1'b1;
        @(negedge clk); deep_enter_i = 1'b0;
        repeat (n) @(negedge clk);
        wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (grant_valid_o !== 1'b0 || grant_state_o !== 3'd0) begin
            fails++;
            $display("FAIL R1 reset: got valid=%0b state=%0d expected valid=0 state=0",
                     grant_valid_o, grant_state_o);
        end
        rst = 1'b0;
        settle(2);
        request(3'd0, 3'd0, "R3");
        request(3'd1, 3'd1, "R3");
        request(3'd6, 3'd6, "R9");

        for (int i = 0; i < 4; i++) deep_stay(10);
        irq_period = 4; settle(50);
        request(3'd6, 3'd3, "R6");
        request(3'd7, 3'd3, "R6");
        request(3'd3, 3'd3, "R9");

        irq_period = 2; settle(50);
        request(3'd6, 3'd1, "R8");
        request(3'd3, 3'd1, "R7");
        request(3'd7, 3'd1, "R7");

        en_c1_i = 1'b0;
        request(3'd6, 3'd3, "R10");
        request(3'd3, 3'd3, "R10");
        en_c3_i = 1'b0;
        request(3'd7, 3'd7, "R10");
        en_c3_i = 1'b1; en_c1_i = 1'b1;

        irq_period = 0; settle(50);
        request(3'd6, 3'd6, "R4");
        irq_period = 2; settle(50);
        request(3'd6, 3'd1, "R4");

        for (int i = 0; i < 4; i++) deep_stay(120);
        request(3'd6, 3'd6, "R5");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); wake_i = 1'b1;
            @(negedge clk); wake_i = 1'b0;
        end
        request(3'd6, 3'd6, "R11");
        deep_stay(10);
        request(3'd6, 3'd6, "R5");
        for (int i = 0; i < 3; i++) deep_stay(10);
        request(3'd6, 3'd1, "R5");

        win_len_i = 16'd300; rate_thr_c3_i = 8'd255; rate_thr_c1_i = 8'd255;
        irq_period = 1; settle(700);
        request(3'd6, 3'd1, "R12");
        request(3'd0, 3'd0, "R3");
        settle(3);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule